// File: doc/BRIEF.md
# Two-Stage Emulation Address Mapper

This block classifies each bus cycle of an emulated 32-bit processor. A first stage holds a small set of window registers. Each window names one 1 MB region of the 4 GB address space. A cycle whose address lands in a window is folded into a compact 16 MB mapping space, where the window's slot number supplies the top address bits. A second stage looks up a per-block attribute word in that space. The attribute word decides whether the cycle is served by emulation memory or by the target's own memory. It also gives the wait states to insert, flags a narrow bus, and says whether a write into emulation memory must be dropped.

Addresses that hit no window go to target memory with no wait states and raise a miss flag. The attribute blocks come in two sizes, chosen by a mode bit: small blocks for fine mapping, or large blocks for fast operation. Software first programs the mode and the windows, then commits them. The committed organisation stays frozen until a mapper-clear command. Attribute words can still be written after the commit. The write-protect attribute only takes effect while realtime emulation is running, so the debugger can still load code into a protected region when the emulation is halted. Every output is registered and appears one clock after the cycle is presented.

Top module: `emu_addr_mapper`

## Requirements
- R1: A cycle hits window slot k when slot k is valid and its 12-bit base equals address bits [31:20]. The folded address is then {k[3:0], address[19:0]}. If several valid slots carry the same base, the lowest slot number wins.
- R2: A valid cycle that hits no window gives wb_miss=1 and tgt_sel=1, with emu_sel=0, wr_inhibit=0, bus_narrow=0 and wait_cnt=0.
- R3: In fine mode (control bit 0 = 0), the attribute word is selected by folded address bits [23:12], so each block is 4 KB. An attribute write (cfg_sel=2) stores into the block numbered by cfg_idx[11:0].
- R4: In coarse mode (control bit 0 = 1), the attribute word is selected by folded address bits [23:19], so each block is 512 KB. An attribute write stores into the block numbered by cfg_idx[4:0].
- R5: On a hit, the source is chosen by attribute bit 0 (emulation). For a read with bit 0 set, emu_sel=1 and tgt_sel=0. For a read with bit 0 clear, emu_sel=0 and tgt_sel=1. For a write with bit 0 set, emu_sel=1 and tgt_sel=1, because emulation memory sits beside the target.
- R6: wr_inhibit=1 exactly when the cycle is a write that hits a block whose attribute bits 0 and 1 (emulation, protect) are both set, and rt_run=1. When rt_run=0 the same write is not inhibited.
- R7: On a hit, wait_cnt shows attribute bits [5:3] and bus_narrow shows attribute bit 2.
- R8: A control write (cfg_sel=0, data bit 0 = coarse mode, data bit 1 = commit) sets the mode. If the commit bit is set, it also locks the organisation. While locked, control writes and window writes (cfg_sel=1, cfg_idx[3:0] = slot, data[11:0] = base, data[12] = valid) are ignored and set cfg_err, which stays set. Attribute writes are still accepted while locked.
- R9: A clear command (cfg_sel=3) unlocks the organisation, clears cfg_err, invalidates all windows, zeroes all attribute words and returns the mode to fine.
- R10: Outputs are registered: they reflect the cycle presented one clock earlier. When cpu_valid is 0, every output except cfg_err is 0.
- R11: After reset, all outputs are 0, the mapper is unlocked and in fine mode, no window is valid and all attributes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | A bus cycle is presented |
| cpu_addr | input | 32 | Cycle address |
| cpu_write | input | 1 | 1 = write cycle, 0 = read or fetch |
| rt_run | input | 1 | Realtime emulation is running |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 window slot, 2 attribute, 3 clear |
| cfg_idx | input | 12 | Window slot or attribute block number |
| cfg_data | input | 16 | Configuration payload |
| emu_sel | output | 1 | Emulation memory takes part in the cycle |
| tgt_sel | output | 1 | Target memory takes part in the cycle |
| wr_inhibit | output | 1 | Drop the write into emulation memory |
| wait_cnt | output | 3 | Wait states to insert |
| bus_narrow | output | 1 | Block uses the narrow bus width |
| wb_miss | output | 1 | Address hit no window |
| cfg_err | output | 1 | Sticky flag for a write refused while locked |

## Verification
Directed cycles cover several cases: neighbouring fine blocks inside one window, which shows whether the block boundary sits at bit 12; duplicate window bases, which shows the priority; and protected writes with rt_run both high and low, which isolates the realtime condition. Coarse mode is checked with addresses just below and just above a 512 KB boundary, and at the last byte of that block. This separates the two granularities. Refused configuration writes are followed by cycles into the window that was refused. Random cycles then mix window hits, misses, reads, writes and rt_run settings against randomly written attributes, in both modes. A reference model predicts every output.

// File: rtl/emap_pkg.sv
package emap_pkg;
   typedef enum logic [1:0] {
      CFG_CTRL   = 2'd0,
      CFG_WBENCH = 2'd1,
      CFG_ATTR   = 2'd2,
      CFG_MAPRST = 2'd3
   } cfg_sel_e;

   // attribute word layout
   localparam int ATTR_EMUL     = 0;
   localparam int ATTR_PROT     = 1;
   localparam int ATTR_NARROW   = 2;
   localparam int ATTR_WAIT_LSB = 3;

   // control word layout
   localparam int CTRL_FAST   = 0;
   localparam int CTRL_COMMIT = 1;
endpackage

// File: rtl/emap_ctrl.sv
module emap_ctrl
   import emap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  cfg_sel_e   cfg_sel,
   input  logic [1:0] ctrl_bits,
   output logic       fast_mode,
   output logic       locked,
   output logic       cfg_err,
   output logic       wb_we,
   output logic       attr_we,
   output logic       map_clr
);
   logic org_wr;

   always_comb begin
      map_clr = cfg_we && (cfg_sel == CFG_MAPRST);
      org_wr  = cfg_we && ((cfg_sel == CFG_CTRL) || (cfg_sel == CFG_WBENCH));
      wb_we   = cfg_we && (cfg_sel == CFG_WBENCH) && !locked;
      attr_we = cfg_we && (cfg_sel == CFG_ATTR);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_mode <= 1'b0;
         locked    <= 1'b0;
         cfg_err   <= 1'b0;
      end else if (map_clr) begin
         fast_mode <= 1'b0;
         locked    <= 1'b0;
         cfg_err   <= 1'b0;
      end else if (org_wr) begin
         if (locked) begin
            cfg_err <= 1'b1;
         end else if (cfg_sel == CFG_CTRL) begin
            fast_mode <= ctrl_bits[CTRL_FAST];
            locked    <= ctrl_bits[CTRL_COMMIT];
         end
      end
   end
endmodule

// File: rtl/emap_premap.sv
module emap_premap #(
   parameter  int ADDR_W   = 32,
   parameter  int WB_COUNT = 16,
   parameter  int WB_BITS  = 20,
   localparam int WBI_W    = $clog2(WB_COUNT),
   localparam int BASE_W   = ADDR_W - WB_BITS,
   localparam int MAP_W    = WB_BITS + WBI_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wb_we,
   input  logic [WBI_W-1:0]  wb_slot,
   input  logic [BASE_W-1:0] wb_base,
   input  logic              wb_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              hit,
   output logic [MAP_W-1:0]  map_addr
);
   logic [WB_COUNT-1:0] match;
   logic [WBI_W-1:0]    slot;

   for (genvar g = 0; g < WB_COUNT; g++) begin : g_slot
      logic [BASE_W-1:0] base_q;
      logic              vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q <= '0;
            vld_q  <= 1'b0;
         end else if (clr) begin
            base_q <= '0;
            vld_q  <= 1'b0;
         end else if (wb_we && (wb_slot == WBI_W'(g))) begin
            base_q <= wb_base;
            vld_q  <= wb_valid;
         end
      end

      assign match[g] = vld_q && (base_q == cpu_addr[ADDR_W-1:WB_BITS]);
   end

   // lowest slot number wins
   always_comb begin
      slot = '0;
      for (int i = WB_COUNT - 1; i >= 0; i--) begin
         if (match[i]) slot = WBI_W'(i);
      end
   end

   assign hit      = |match;
   assign map_addr = {slot, cpu_addr[WB_BITS-1:0]};
endmodule

// File: rtl/emap_attr_table.sv
module emap_attr_table #(
   parameter  int MAP_W     = 24,
   parameter  int SLOW_BITS = 12,
   parameter  int FAST_BITS = 19,
   parameter  int ATTR_W    = 6,
   localparam int IDX_W     = MAP_W - SLOW_BITS,
   localparam int FIDX_W    = MAP_W - FAST_BITS,
   localparam int SHIFT     = FAST_BITS - SLOW_BITS,
   localparam int DEPTH     = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic              fast,
   input  logic [IDX_W-1:0]  widx,
   input  logic [ATTR_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rblk,
   output logic [ATTR_W-1:0] attr
);
   logic [ATTR_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  wa;
   logic [IDX_W-1:0]  ra;

   // coarse blocks alias to the first fine entry they cover
   always_comb begin
      wa = fast ? {widx[FIDX_W-1:0], {SHIFT{1'b0}}} : widx;
      ra = fast ? {rblk[IDX_W-1:SHIFT], {SHIFT{1'b0}}} : rblk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[wa] <= wdata;
      end
   end

   assign attr = mem[ra];
endmodule

// File: rtl/emu_addr_mapper.sv
module emu_addr_mapper
   import emap_pkg::*;
#(
   parameter  int ADDR_W        = 32,
   parameter  int WB_COUNT      = 16,
   parameter  int WB_BITS       = 20,
   parameter  int SLOW_BLK_BITS = 12,
   parameter  int FAST_BLK_BITS = 19,
   parameter  int WAIT_W        = 3,
   parameter  int CFG_W         = 16,
   localparam int WBI_W         = $clog2(WB_COUNT),
   localparam int BASE_W        = ADDR_W - WB_BITS,
   localparam int MAP_W         = WB_BITS + WBI_W,
   localparam int IDX_W         = MAP_W - SLOW_BLK_BITS,
   localparam int ATTR_W        = ATTR_WAIT_LSB + WAIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_write,
   input  logic              rt_run,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [CFG_W-1:0]  cfg_data,
   output logic              emu_sel,
   output logic              tgt_sel,
   output logic              wr_inhibit,
   output logic [WAIT_W-1:0] wait_cnt,
   output logic              bus_narrow,
   output logic              wb_miss,
   output logic              cfg_err
);
   initial begin
      assert (WB_COUNT >= 2 && (1 << WBI_W) == WB_COUNT)
         else $fatal(1, "WB_COUNT must be a power of two");
      assert (FAST_BLK_BITS > SLOW_BLK_BITS && WB_BITS >= FAST_BLK_BITS)
         else $fatal(1, "block sizes must nest inside a window");
      assert (CFG_W > BASE_W && CFG_W >= ATTR_W && IDX_W >= WBI_W)
         else $fatal(1, "configuration port too narrow");
   end

   logic              fast_mode, locked, wb_we, attr_we, map_clr;
   logic              hit;
   logic [MAP_W-1:0]  map_addr;
   logic [ATTR_W-1:0] attr;
   logic              unused_bits;

   assign unused_bits = ^{cfg_data, map_addr[SLOW_BLK_BITS-1:0], locked};

   emap_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel_e'(cfg_sel)),
      .ctrl_bits (cfg_data[1:0]),
      .fast_mode (fast_mode),
      .locked    (locked),
      .cfg_err   (cfg_err),
      .wb_we     (wb_we),
      .attr_we   (attr_we),
      .map_clr   (map_clr)
   );

   emap_premap #(
      .ADDR_W   (ADDR_W),
      .WB_COUNT (WB_COUNT),
      .WB_BITS  (WB_BITS)
   ) u_premap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (map_clr),
      .wb_we    (wb_we),
      .wb_slot  (cfg_idx[WBI_W-1:0]),
      .wb_base  (cfg_data[BASE_W-1:0]),
      .wb_valid (cfg_data[BASE_W]),
      .cpu_addr (cpu_addr),
      .hit      (hit),
      .map_addr (map_addr)
   );

   emap_attr_table #(
      .MAP_W     (MAP_W),
      .SLOW_BITS (SLOW_BLK_BITS),
      .FAST_BITS (FAST_BLK_BITS),
      .ATTR_W    (ATTR_W)
   ) u_table (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (map_clr),
      .we    (attr_we),
      .fast  (fast_mode),
      .widx  (cfg_idx),
      .wdata (cfg_data[ATTR_W-1:0]),
      .rblk  (map_addr[MAP_W-1:SLOW_BLK_BITS]),
      .attr  (attr)
   );

   logic              on_hit, emul;
   logic              emu_d, tgt_d, inh_d, miss_d, nar_d;
   logic [WAIT_W-1:0] wait_d;

   always_comb begin
      on_hit = cpu_valid && hit;
      emul   = attr[ATTR_EMUL];
      emu_d  = on_hit && emul;
      tgt_d  = cpu_valid && (!hit || !emul || cpu_write);
      inh_d  = emu_d && cpu_write && attr[ATTR_PROT] && rt_run;
      miss_d = cpu_valid && !hit;
      nar_d  = on_hit && attr[ATTR_NARROW];
      wait_d = on_hit ? attr[ATTR_WAIT_LSB +: WAIT_W] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         emu_sel    <= 1'b0;
         tgt_sel    <= 1'b0;
         wr_inhibit <= 1'b0;
         wb_miss    <= 1'b0;
         bus_narrow <= 1'b0;
         wait_cnt   <= '0;
      end else begin
         emu_sel    <= emu_d;
         tgt_sel    <= tgt_d;
         wr_inhibit <= inh_d;
         wb_miss    <= miss_d;
         bus_narrow <= nar_d;
         wait_cnt   <= wait_d;
      end
   end
endmodule

// File: rtl/emu_addr_mapper_chk.sv
module emu_addr_mapper_chk #(
   parameter int WAIT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_valid,
   input logic              cpu_write,
   input logic              rt_run,
   input logic              cfg_we,
   input logic [1:0]        cfg_sel,
   input logic              emu_sel,
   input logic              tgt_sel,
   input logic              wr_inhibit,
   input logic [WAIT_W-1:0] wait_cnt,
   input logic              bus_narrow,
   input logic              wb_miss,
   input logic              cfg_err
);
   a_r2_miss_target: assert property (@(posedge clk) disable iff (!rst_n)
      wb_miss |-> (tgt_sel && !emu_sel && !wr_inhibit && !bus_narrow && wait_cnt == '0));

   a_r5_read_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !cpu_write) |=> ($countones({emu_sel, tgt_sel}) == 1));

   a_r6_inhibit_parallel: assert property (@(posedge clk) disable iff (!rst_n)
      wr_inhibit |-> (emu_sel && tgt_sel && !wb_miss));

   a_r6_inhibit_needs_rt: assert property (@(posedge clk) disable iff (!rst_n)
      (!rt_run || !cpu_write) |=> !wr_inhibit);

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !(cfg_we && cfg_sel == 2'd3)) |=> cfg_err);

   a_r9_clear_err: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3) |=> !cfg_err);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_valid |=> (!emu_sel && !tgt_sel && !wr_inhibit && !wb_miss && !bus_narrow && wait_cnt == '0));
endmodule

bind emu_addr_mapper emu_addr_mapper_chk #(.WAIT_W(WAIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_write  (cpu_write),
   .rt_run     (rt_run),
   .cfg_we     (cfg_we),
   .cfg_sel    (cfg_sel),
   .emu_sel    (emu_sel),
   .tgt_sel    (tgt_sel),
   .wr_inhibit (wr_inhibit),
   .wait_cnt   (wait_cnt),
   .bus_narrow (bus_narrow),
   .wb_miss    (wb_miss),
   .cfg_err    (cfg_err)
);

// File: tb/emu_addr_mapper_bench.sv
`timescale 1ns/1ps
module emu_addr_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_write = 1'b0;
   logic        rt_run = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [11:0] cfg_idx = '0;
   logic [15:0] cfg_data = '0;
   logic        emu_sel, tgt_sel, wr_inhibit, bus_narrow, wb_miss, cfg_err;
   logic [2:0]  wait_cnt;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   emu_addr_mapper u_emu_addr_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
      .cpu_write(cpu_write), .rt_run(rt_run), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data), .emu_sel(emu_sel), .tgt_sel(tgt_sel),
      .wr_inhibit(wr_inhibit), .wait_cnt(wait_cnt), .bus_narrow(bus_narrow),
      .wb_miss(wb_miss), .cfg_err(cfg_err)
   );

   // reference model of the programmed state
   bit        m_fast, m_lock, m_err;
   bit [11:0] m_base [16];
   bit        m_vld [16];
   bit [5:0]  m_attr [4096];

   task automatic model_clear();
      m_fast = 0; m_lock = 0; m_err = 0;
      for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_vld[i] = 0; end
      for (int i = 0; i < 4096; i++) m_attr[i] = '0;
   endtask

   // packed {emu, tgt, inh, miss, narrow, wait[2:0]}
   function automatic logic [7:0] expect_out(logic [31:0] a, bit wr, bit rt);
      bit        hit = 0;
      int        e = 0;
      logic [23:0] mapped;
      logic [11:0] idx;
      logic [5:0]  at;
      for (int i = 0; i < 16; i++)
         if (!hit && m_vld[i] && m_base[i] == a[31:20]) begin hit = 1; e = i; end
      if (!hit) return 8'b0101_0000;
      mapped = {4'(e), a[19:0]};
      idx = m_fast ? {mapped[23:19], 7'b0} : mapped[23:12];
      at = m_attr[idx];
      return {at[0], (!at[0] || wr), (wr && at[0] && at[1] && rt), 1'b0, at[2], at[5:3]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(logic [1:0] sel, logic [11:0] idx, logic [15:0] d);
      cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_data = d;
      case (sel)
         2'd0: if (m_lock) m_err = 1; else begin m_fast = d[0]; m_lock = d[1]; end
         2'd1: if (m_lock) m_err = 1; else begin m_base[idx[3:0]] = d[11:0]; m_vld[idx[3:0]] = d[12]; end
         2'd2: m_attr[m_fast ? {idx[4:0], 7'b0} : idx] = d[5:0];
         default: model_clear();
      endcase
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic probe(string req, logic [31:0] a, bit wr, bit rt);
      logic [7:0] exp;
      exp = expect_out(a, wr, rt);
      cpu_valid = 1; cpu_addr = a; cpu_write = wr; rt_run = rt;
      @(negedge clk);
      cpu_valid = 0;
      check(req, {24'b0, emu_sel, tgt_sel, wr_inhibit, wb_miss, bus_narrow, wait_cnt}, {24'b0, exp});
   endtask

   function automatic logic [31:0] rand_addr();
      int s = $urandom % 16;
      if (($urandom % 10) < 7 && m_vld[s]) return {m_base[s], 20'($urandom)};
      return $urandom;
   endfunction

   task automatic random_phase(int n);
      for (int k = 0; k < n; k++) begin
         if (($urandom % 3) == 0) cfg(2'd2, 12'($urandom), 16'($urandom));
         probe("R5", rand_addr(), 1'($urandom), 1'($urandom));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      check("R11", {26'b0, emu_sel, tgt_sel, wr_inhibit, wb_miss, bus_narrow, cfg_err}, 32'b0);
      check("R11", {29'b0, wait_cnt}, 32'b0);
      // R2 nothing programmed
      probe("R2", 32'h1234_5678, 0, 0);
      probe("R2", 32'hFFFF_FFFF, 1, 1);
      // R10 idle cycle after activity
      @(negedge clk);
      check("R10", {26'b0, emu_sel, tgt_sel, wr_inhibit, wb_miss, bus_narrow, 1'b0}, 32'b0);

      // windows: slot 2 and 3 share a base (R1)
      cfg(2'd1, 12'd0, 16'h1000);
      cfg(2'd1, 12'd1, 16'h1FFF);
      cfg(2'd1, 12'd2, 16'h1123);
      cfg(2'd1, 12'd3, 16'h1123);
      cfg(2'd0, 12'd0, 16'h0002);   // fine mode, commit
      cfg(2'd2, 12'h245, 16'b101_1_1_1);  // wait5 narrow prot emul
      cfg(2'd2, 12'h246, 16'b010_0_0_0);  // wait2, target
      cfg(2'd2, 12'h345, 16'b111_0_0_1);  // slot 3 copy, wait7
      probe("R1", 32'h1234_5678, 0, 0);
      check("R1", {29'b0, wait_cnt}, 32'd5);
      probe("R3", 32'h1234_6000, 0, 0);
      check("R3", {29'b0, wait_cnt}, 32'd2);
      probe("R3", 32'h1234_5FFF, 0, 0);
      probe("R7", 32'h1234_5000, 0, 0);
      check("R7", {31'b0, bus_narrow}, 32'd1);
      probe("R6", 32'h1234_5678, 1, 1);
      check("R6", {31'b0, wr_inhibit}, 32'd1);
      probe("R6", 32'h1234_5678, 1, 0);
      check("R6", {31'b0, wr_inhibit}, 32'd0);
      probe("R5", 32'h1234_6010, 1, 1);
      probe("R2", 32'h5550_0000, 0, 0);

      // R8 locked organisation
      cfg(2'd1, 12'd5, 16'h1555);
      check("R8", {31'b0, cfg_err}, 32'd1);
      probe("R8", 32'h5550_0010, 0, 0);
      check("R8", {31'b0, wb_miss}, 32'd1);
      cfg(2'd0, 12'd0, 16'h0003);
      probe("R8", 32'h1234_6000, 0, 0);
      cfg(2'd2, 12'h001, 16'b011_0_0_1);
      probe("R8", 32'h0000_1004, 0, 0);
      check("R8", {31'b0, cfg_err}, 32'd1);
      random_phase(400);

      // R9 clear
      cfg(2'd3, 12'd0, 16'h0000);
      check("R9", {31'b0, cfg_err}, 32'd0);
      probe("R9", 32'h1234_5678, 0, 0);
      cfg(2'd1, 12'd2, 16'h1123);
      probe("R9", 32'h1234_5678, 0, 0);
      check("R9", {29'b0, wait_cnt}, 32'd0);

      // R4 coarse mode: slot 2 upper half is coarse block 5
      cfg(2'd1, 12'd7, 16'h1ABC);
      cfg(2'd1, 12'd12, 16'h1000);
      cfg(2'd0, 12'd0, 16'h0003);
      cfg(2'd2, 12'd5, 16'b110_1_0_1);
      cfg(2'd2, 12'd4, 16'b001_0_0_0);
      probe("R4", 32'h1238_0000, 0, 0);
      check("R4", {29'b0, wait_cnt}, 32'd6);
      probe("R4", 32'h123F_FFFF, 0, 0);
      probe("R4", 32'h1237_FFFF, 0, 0);
      check("R4", {29'b0, wait_cnt}, 32'd1);
      probe("R4", 32'h1230_0000, 1, 1);
      random_phase(400);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule